// File: doc/BRIEF.md
# Bit-Reversal Frame Reorder Buffer

This block sits between a transform core and the logic that consumes its results. It takes one frame of N samples, where N is a power of two, and changes the index order from bit-reversed to linear. The same mapping also converts linear order to bit-reversed order. Input samples are written as they arrive, and the valid qualifier may have gaps. A frame is played out only after all N of its samples are stored. It then leaves as an unbroken run of N cycles, marked by a pulse on the first sample and a pulse on the last.

Two frame memories take turns. While one bank fills at the natural address, the other bank drains at the bit-reversed address. Because of this, frames that arrive back to back leave back to back. A synchronous reset abandons the frame being collected and any frame being played out. Collection then starts again at index 0.

Top module: `bitrev_reorder`

## Requirements
- R1: Each input sample is stored when `in_valid` is high at a rising clock edge, and idle cycles between samples do not change the frame. A frame is complete after N accepted samples.
- R2: After a frame is complete, `out_valid` is high on N consecutive cycles for that frame.
- R3: `out_first` is high only on the first valid output cycle of each frame. Whenever it is high, `out_valid` is also high.
- R4: `out_last` is high only on the last valid output cycle of each frame. Whenever it is high, `out_valid` is also high.
- R5: When input frames arrive with no idle cycles between them, the output frames also follow each other with no idle cycles.
- R6: `rst` is sampled at the clock edge. After that edge, no output of any earlier frame appears. The next accepted sample is stored as index 0 of a new frame.
- R7: Output position i of a frame (i = 0 for the first output) carries the input sample whose index is i with its log2(N) address bits reversed.
- R8: The first output of a frame appears two clock edges after the edge that accepts the frame's last sample, provided the previous frame has finished playing out.
- R9: While reset is applied, and after it, `out_valid`, `out_first` and `out_last` stay low until a frame is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | W | Input sample |
| in_valid | input | 1 | Input sample qualifier |
| out_data | output | W | Reordered output sample |
| out_valid | output | 1 | Output sample qualifier |
| out_first | output | 1 | First sample of an output frame |
| out_last | output | 1 | Last sample of an output frame |

## Verification
The assertions check four rules on every cycle:
- The two frame markers occur only together with `out_valid`.
- An output run never breaks before its last sample.
- A first marker is never repeated inside a run.
- Reset empties the output.

Only the bench's scenarios can show the rest, because each depends on the content and timing of whole frames:
- the bit-reversed data mapping;
- the exact two-edge latency;
- seamless playout of back-to-back frames;
- restart at index 0 after a reset that arrives in the middle of a frame or in the middle of playout.

// File: rtl/bitrev_reorder.sv
module bitrev_reorder #(
  parameter int LOG2N = 4,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  output logic         out_first,
  output logic         out_last
);
  localparam int N = 1 << LOG2N;
  localparam logic [LOG2N-1:0] LAST_IDX = LOG2N'(N - 1);

  logic [W-1:0]     mem [2][N];
  logic [LOG2N-1:0] wr_idx, rd_idx;
  logic             wr_bank, rd_bank, rd_active;
  logic [1:0]       full;

  function automatic logic [LOG2N-1:0] rev(input logic [LOG2N-1:0] a);
    for (int b = 0; b < LOG2N; b++) rev[b] = a[LOG2N-1-b];
  endfunction

  wire wr_done = in_valid && (wr_idx == LAST_IDX);
  wire rd_done = rd_active && (rd_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (in_valid) mem[wr_bank][wr_idx] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx  <= '0;
      wr_bank <= 1'b0;
    end else if (in_valid) begin
      wr_idx <= wr_idx + 1'b1;
      if (wr_done) wr_bank <= ~wr_bank;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 2'b00;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (wr_done && wr_bank == k[0]) full[k] <= 1'b1;
        else if (rd_done && rd_bank == k[0]) full[k] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_active <= 1'b0;
      rd_idx    <= '0;
      rd_bank   <= 1'b0;
    end else if (rd_active) begin
      rd_idx <= rd_idx + 1'b1;
      if (rd_done) begin
        rd_bank   <= ~rd_bank;
        rd_active <= full[~rd_bank];
      end
    end else if (full[rd_bank]) begin
      rd_active <= 1'b1;
      rd_idx    <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_active) out_data <= mem[rd_bank][rev(rd_idx)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= rd_active;
      out_first <= rd_active && (rd_idx == '0);
      out_last  <= rd_done;
    end
  end

  // R3
  first_has_valid_chk: assert property (@(posedge clk) disable iff (rst) out_first |-> out_valid);
  // R4
  last_has_valid_chk: assert property (@(posedge clk) disable iff (rst) out_last |-> out_valid);
  // R2
  run_unbroken_chk: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_last) |=> out_valid);
  // R3
  first_once_chk: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_last) |=> !out_first);
  // R6
  reset_flush_chk: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: tb/sim_bitrev_reorder.sv
module sim_bitrev_reorder;
  localparam int LOG2N = 4;
  localparam int W = 16;
  localparam int N = 1 << LOG2N;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] out_data;
  logic out_valid, out_first, out_last;

  bitrev_reorder #(.LOG2N(LOG2N), .W(W)) u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_valid(out_valid), .out_first(out_first), .out_last(out_last));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, last_end = 0, widx = 0;
  string phase = "R9";
  logic [W-1:0] fbuf [N];
  logic [W-1:0] exp_d [int];
  logic [1:0]   exp_f [int];
  logic [W-1:0] seq = 16'h1000;

  function automatic int brev(int a);
    int r = 0;
    for (int b = 0; b < LOG2N; b++) if (a[b]) r |= 1 << (LOG2N - 1 - b);
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      exp_d.delete(); exp_f.delete();
      widx = 0; last_end = 0;
    end else if (in_valid) begin
      fbuf[widx] = in_data;
      widx++;
      if (widx == N) begin
        int st;
        st = (cyc + 2 > last_end + 1) ? cyc + 2 : last_end + 1;
        for (int i = 0; i < N; i++) begin
          exp_d[st + i] = fbuf[brev(i)];
          exp_f[st + i] = {i == 0, i == N - 1};
        end
        last_end = st + N - 1;
        widx = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 0) begin
      logic ev, ef, el;
      ev = exp_d.exists(cyc);
      ef = ev && exp_f[cyc][1];
      el = ev && exp_f[cyc][0];
      tests++;
      if (out_valid !== ev) begin
        fails++; $display("FAIL R2 (%s) cyc %0d out_valid=%b expected %b", phase, cyc, out_valid, ev);
      end
      if (out_first !== ef) begin
        fails++; $display("FAIL R3 (%s) cyc %0d out_first=%b expected %b", phase, cyc, out_first, ef);
      end
      if (out_last !== el) begin
        fails++; $display("FAIL R4 (%s) cyc %0d out_last=%b expected %b", phase, cyc, out_last, el);
      end
      if (ev && out_data !== exp_d[cyc]) begin
        fails++; $display("FAIL R7 (%s) cyc %0d out_data=%h expected %h", phase, cyc, out_data, exp_d[cyc]);
      end
    end
  end

  task automatic send(int count, int gapmod);
    for (int k = 0; k < count; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = seq; seq = seq + 16'h0107;
      if (gapmod > 0 && (k % gapmod) == 1) begin
        @(negedge clk); in_valid = 0;
        if ((k % 3) == 0) begin @(negedge clk); end
      end
    end
    @(negedge clk); in_valid = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic b2b(int frames);
    for (int k = 0; k < frames * N; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = seq; seq = seq + 16'h0031;
    end
    @(negedge clk); in_valid = 0;
  endtask

  initial begin
    int first_seen;
    idle(3);
    rst = 0;
    idle(3);
    phase = "R1"; send(N, 3); idle(N + 6);
    phase = "R8";
    b2b(1);
    first_seen = 0;
    for (int k = 0; k < 4; k++) begin
      if (out_valid) first_seen = 1;
      @(negedge clk);
    end
    tests++;
    if (first_seen !== 1) begin
      fails++; $display("FAIL R8 first output not seen in window: got %0d expected 1", first_seen);
    end
    idle(N + 4);
    phase = "R5"; b2b(4); idle(N + 6);
    phase = "R1"; send(2 * N, 2); idle(2 * N + 6);
    phase = "R6";
    send(N / 2, 0);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    send(N, 0); idle(N / 2);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    idle(N + 4);
    send(N, 4); idle(N + 6);
    phase = "R5"; send(N, 5); b2b(2); idle(3 * N + 6);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    fails++; tests++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule